// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns a decoded addressing mode and an instruction operand into a 24-bit effective address for an 8/16-bit accumulator processor whose memory is split into 64 KiB banks and whose zero page can be moved anywhere in bank 0. It reads the two index registers, the stack pointer, the direct-page base, the data and program bank registers, the emulation flag and the index-width flag. For each request it returns the effective address, a mask that limits which address bits may change while the bytes of a multi-byte operand are walked, a page-crossing "dummy" address for the throw-away read cycle, and a flag that tells the sequencer to drop one optional cycle.

A request is presented with a one-cycle strobe; the results are registered and appear on the next clock, then hold until the next request. A separate combinational port steps an address up or down by one under a mask, which the bus sequencer uses between the bytes of a wide access.

Top module: `bank_ea_gen`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high; the four result outputs change only one clock after a strobed request and otherwise hold; reset clears every output to zero.
- R2: Mode 0 (bank absolute) gives `ea_addr` = {data_bank, 16'h0000} + operand[15:0] modulo 2^24, `inc_mask` = 24'hFFFFFF, `dummy_addr` = `ea_addr`, `skip_cycle` = 0.
- R3: Modes 1/2 (X indexed) and 3/4 (Y indexed) give `ea_addr` = {data_bank,16'h0} + operand[15:0] + index modulo 2^24 and `dummy_addr` = {data_bank,16'h0} + {operand[15:8], low byte of (operand[15:0] + index)}, with `inc_mask` = 24'hFFFFFF.
- R4: `skip_cycle` is 1 for the read modes 1 and 3 only when `dummy_addr` equals `ea_addr` and `idx_narrow` is 1; the write modes 2 and 4 never skip.
- R5: Mode 5 gives `ea_addr` = operand; mode 6 gives operand + `idx_x` modulo 2^24; both with `inc_mask` = 24'hFFFFFF, dummy equal to the address and no skip.
- R6: Mode 7 (indexed indirect jump) gives `ea_addr` = {prog_bank, (operand[15:0] + `idx_x`) mod 2^16}, `inc_mask` = 24'h00FFFF, no skip.
- R7: Mode 8 (direct) gives `ea_addr` = {8'h00, (dp_base + operand[7:0]) mod 2^16}; `skip_cycle` = 1 exactly when dp_base[7:0] is zero; `inc_mask` is 24'h0000FF when that low byte is zero and `emu_mode` is 1, else 24'h00FFFF.
- R8: Modes 9 (X) and 10 (Y) form s = dp_base + operand[7:0] + index; with dp_base[7:0] zero and `emu_mode` 1 the address is {8'h00, dp_base[15:8], s[7:0]}, otherwise {8'h00, s mod 2^16}; `inc_mask` = 24'h00FFFF and `skip_cycle` = 1 exactly when dp_base[7:0] is zero.
- R9: Mode 11 (stack relative) gives {8'h00, (base + operand[7:0]) mod 2^16} where base is {8'h01, stk_ptr[7:0]} when `emu_mode` is 1 and `stk_ptr` otherwise; `inc_mask` = 24'h00FFFF, no skip.
- R10: `step_addr_o` = (`step_addr_i` & ~mask) | ((`step_addr_i` + 1, or − 1 when `step_down` is 1) & mask) combinationally: bits outside the mask never change.
- R11: Mode codes 12 to 15 give all-zero address, mask and dummy and no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 4 | Addressing mode code (0..11) |
| operand | input | 24 | Instruction operand bytes |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| stk_ptr | input | 16 | Stack pointer |
| dp_base | input | 16 | Direct-page base register |
| data_bank | input | 8 | Data bank register |
| prog_bank | input | 8 | Program bank register |
| emu_mode | input | 1 | Emulation mode flag |
| idx_narrow | input | 1 | Index registers are 8 bits wide |
| out_valid | output | 1 | Results belong to the previous cycle's request |
| ea_addr | output | 24 | Effective address |
| inc_mask | output | 24 | Bits allowed to change when stepping |
| dummy_addr | output | 24 | Uncorrected page address for the dummy read |
| skip_cycle | output | 1 | Drop the optional cycle |
| step_addr_i | input | 24 | Address to step |
| step_mask_i | input | 24 | Mask for the step |
| step_down | input | 1 | 1 = decrement, 0 = increment |
| step_addr_o | output | 24 | Stepped address |

## Verification
On every clock the assertions check the strobe-to-valid latency, that the stepper never disturbs bits outside its mask, that direct-page and stack modes land in bank 0, that the indexed dummy address shares the real address's low byte, that only read-indexed and direct-page modes may request a skip, and that the emulation-mode direct-indexed result keeps the page of the base register. The exact arithmetic, the carry from the operand into the bank byte, the page-crossing decision against the index width, the emulation mask choice and the holding of results between requests are shown only by the bench's directed and random scenarios against its own reference model.

// File: rtl/bea_pkg.sv
package bea_pkg;
    parameter int unsigned ADDR_W = 24;
    parameter int unsigned WORD_W = 16;
    localparam int unsigned BANK_W = ADDR_W - WORD_W;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        M_ABS     = 4'd0,
        M_ABSX_RD = 4'd1,
        M_ABSX_WR = 4'd2,
        M_ABSY_RD = 4'd3,
        M_ABSY_WR = 4'd4,
        M_LONG    = 4'd5,
        M_LONGX   = 4'd6,
        M_JINDX   = 4'd7,
        M_DIR     = 4'd8,
        M_DIRX    = 4'd9,
        M_DIRY    = 4'd10,
        M_STKREL  = 4'd11
    } ea_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] dummy;
        logic              skip;
    } ea_res_t;

    localparam logic [ADDR_W-1:0] MASK_FULL = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MASK_WORD = {{BANK_W{1'b0}}, {WORD_W{1'b1}}};
    localparam logic [ADDR_W-1:0] MASK_BYTE = {{(ADDR_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
endpackage

// File: rtl/bea_abs_unit.sv
module bea_abs_unit
    import bea_pkg::*;
(
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [WORD_W-1:0] idx_x,
    input  logic [WORD_W-1:0] idx_y,
    input  logic [BANK_W-1:0] data_bank,
    input  logic [BANK_W-1:0] prog_bank,
    input  logic              idx_narrow,
    output logic              hit,
    output ea_res_t           res
);
    logic [ADDR_W-1:0] bank_base;
    logic [WORD_W-1:0] idx_sel;
    logic [WORD_W-1:0] off_sum;
    logic [ADDR_W-1:0] idx_ea;
    logic [ADDR_W-1:0] idx_dummy;
    logic              is_read_idx;

    always_comb begin
        bank_base   = {data_bank, {WORD_W{1'b0}}};
        idx_sel     = (mode == M_ABSY_RD || mode == M_ABSY_WR) ? idx_y : idx_x;
        off_sum     = operand[WORD_W-1:0] + idx_sel;
        idx_ea      = bank_base + {{BANK_W{1'b0}}, operand[WORD_W-1:0]}
                                + {{BANK_W{1'b0}}, idx_sel};
        idx_dummy   = bank_base + {{BANK_W{1'b0}}, operand[WORD_W-1:BYTE_W],
                                   off_sum[BYTE_W-1:0]};
        is_read_idx = (mode == M_ABSX_RD || mode == M_ABSY_RD);

        hit = 1'b1;
        res = '0;
        unique case (mode)
            M_ABS: begin
                res.ea   = bank_base + {{BANK_W{1'b0}}, operand[WORD_W-1:0]};
                res.mask = MASK_FULL;
            end
            M_ABSX_RD, M_ABSX_WR, M_ABSY_RD, M_ABSY_WR: begin
                res.ea    = idx_ea;
                res.mask  = MASK_FULL;
                res.dummy = idx_dummy;
                res.skip  = is_read_idx && idx_narrow && (idx_ea == idx_dummy);
            end
            M_LONG: begin
                res.ea   = operand;
                res.mask = MASK_FULL;
            end
            M_LONGX: begin
                res.ea   = operand + {{BANK_W{1'b0}}, idx_x};
                res.mask = MASK_FULL;
            end
            M_JINDX: begin
                res.ea   = {prog_bank, off_sum};
                res.mask = MASK_WORD;
            end
            default: hit = 1'b0;
        endcase
        if (!(mode == M_ABSX_RD || mode == M_ABSX_WR ||
              mode == M_ABSY_RD || mode == M_ABSY_WR))
            res.dummy = res.ea;
    end
endmodule

// File: rtl/bea_dp_unit.sv
module bea_dp_unit
    import bea_pkg::*;
(
    input  logic [3:0]        mode,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [WORD_W-1:0] idx_x,
    input  logic [WORD_W-1:0] idx_y,
    input  logic [WORD_W-1:0] stk_ptr,
    input  logic [WORD_W-1:0] dp_base,
    input  logic              emu_mode,
    output logic              hit,
    output ea_res_t           res
);
    localparam logic [BYTE_W-1:0] EMU_STACK_PAGE = 8'h01;

    logic              dp_aligned;
    logic [WORD_W-1:0] op_ext;
    logic [WORD_W-1:0] dir_sum;
    logic [WORD_W-1:0] idx_sum;
    logic [WORD_W-1:0] idx_wrapped;
    logic [WORD_W-1:0] stk_base;
    logic [WORD_W-1:0] stk_sum;

    always_comb begin
        dp_aligned  = (dp_base[BYTE_W-1:0] == '0);
        op_ext      = {{(WORD_W-BYTE_W){1'b0}}, op_lo};
        dir_sum     = dp_base + op_ext;
        idx_sum     = dir_sum + ((mode == M_DIRY) ? idx_y : idx_x);
        idx_wrapped = (dp_aligned && emu_mode)
                    ? {dp_base[WORD_W-1:BYTE_W], idx_sum[BYTE_W-1:0]}
                    : idx_sum;
        stk_base    = emu_mode ? {EMU_STACK_PAGE, stk_ptr[BYTE_W-1:0]} : stk_ptr;
        stk_sum     = stk_base + op_ext;

        hit = 1'b1;
        res = '0;
        unique case (mode)
            M_DIR: begin
                res.ea   = {{BANK_W{1'b0}}, dir_sum};
                res.mask = (dp_aligned && emu_mode) ? MASK_BYTE : MASK_WORD;
                res.skip = dp_aligned;
            end
            M_DIRX, M_DIRY: begin
                res.ea   = {{BANK_W{1'b0}}, idx_wrapped};
                res.mask = MASK_WORD;
                res.skip = dp_aligned;
            end
            M_STKREL: begin
                res.ea   = {{BANK_W{1'b0}}, stk_sum};
                res.mask = MASK_WORD;
            end
            default: hit = 1'b0;
        endcase
        res.dummy = res.ea;
    end
endmodule

// File: rtl/bea_step.sv
module bea_step
    import bea_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic              down,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] moved;

    always_comb begin
        moved  = down ? (addr_i - 1'b1) : (addr_i + 1'b1);
        addr_o = (addr_i & ~mask_i) | (moved & mask_i);
    end
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
    import bea_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [WORD_W-1:0] idx_x,
    input  logic [WORD_W-1:0] idx_y,
    input  logic [WORD_W-1:0] stk_ptr,
    input  logic [WORD_W-1:0] dp_base,
    input  logic [BANK_W-1:0] data_bank,
    input  logic [BANK_W-1:0] prog_bank,
    input  logic              emu_mode,
    input  logic              idx_narrow,
    output logic              out_valid,
    output logic [ADDR_W-1:0] ea_addr,
    output logic [ADDR_W-1:0] inc_mask,
    output logic [ADDR_W-1:0] dummy_addr,
    output logic              skip_cycle,
    input  logic [ADDR_W-1:0] step_addr_i,
    input  logic [ADDR_W-1:0] step_mask_i,
    input  logic              step_down,
    output logic [ADDR_W-1:0] step_addr_o
);
    typedef struct packed {
        logic    vld;
        ea_res_t res;
    } gen_state_t;

    gen_state_t st_d, st_q;
    ea_res_t    abs_res, dp_res;
    logic       abs_hit, dp_hit;

    bea_abs_unit u_abs (
        .mode       (req_mode),
        .operand    (operand),
        .idx_x      (idx_x),
        .idx_y      (idx_y),
        .data_bank  (data_bank),
        .prog_bank  (prog_bank),
        .idx_narrow (idx_narrow),
        .hit        (abs_hit),
        .res        (abs_res)
    );

    bea_dp_unit u_dp (
        .mode     (req_mode),
        .op_lo    (operand[BYTE_W-1:0]),
        .idx_x    (idx_x),
        .idx_y    (idx_y),
        .stk_ptr  (stk_ptr),
        .dp_base  (dp_base),
        .emu_mode (emu_mode),
        .hit      (dp_hit),
        .res      (dp_res)
    );

    bea_step u_step (
        .addr_i (step_addr_i),
        .mask_i (step_mask_i),
        .down   (step_down),
        .addr_o (step_addr_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            if (abs_hit)     st_d.res = abs_res;
            else if (dp_hit) st_d.res = dp_res;
            else             st_d.res = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign ea_addr    = st_q.res.ea;
    assign inc_mask   = st_q.res.mask;
    assign dummy_addr = st_q.res.dummy;
    assign skip_cycle = st_q.res.skip;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(ea_addr) && $stable(skip_cycle))); // R1
    AST_STEP_OUTSIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_addr_o & ~step_mask_i) == (step_addr_i & ~step_mask_i))); // R10
    AST_DP_IN_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == M_DIR || req_mode == M_DIRX ||
                       req_mode == M_DIRY || req_mode == M_STKREL))
        |=> (ea_addr[ADDR_W-1:WORD_W] == '0)); // R7
    AST_DUMMY_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode >= M_ABSX_RD && req_mode <= M_ABSY_WR)
        |=> (dummy_addr[BYTE_W-1:0] == ea_addr[BYTE_W-1:0])); // R3
    AST_SKIP_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_mode == M_ABSX_RD || req_mode == M_ABSY_RD ||
                        req_mode == M_DIR || req_mode == M_DIRX || req_mode == M_DIRY))
        |=> !skip_cycle); // R4
    AST_EMU_DP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && emu_mode && dp_base[BYTE_W-1:0] == '0 &&
         (req_mode == M_DIRX || req_mode == M_DIRY))
        |=> (ea_addr[WORD_W-1:BYTE_W] == $past(dp_base[WORD_W-1:BYTE_W]))); // R8
endmodule

// File: tb/bank_ea_gen_tb_top.sv
`timescale 1ns/1ps
module bank_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic [23:0] operand = '0;
    logic [15:0] idx_x = '0, idx_y = '0, stk_ptr = '0, dp_base = '0;
    logic [7:0]  data_bank = '0, prog_bank = '0;
    logic        emu_mode = 1'b0, idx_narrow = 1'b0;
    logic        out_valid, skip_cycle;
    logic [23:0] ea_addr, inc_mask, dummy_addr;
    logic [23:0] step_addr_i = '0, step_mask_i = '0, step_addr_o;
    logic        step_down = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bank_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .operand(operand), .idx_x(idx_x), .idx_y(idx_y), .stk_ptr(stk_ptr),
        .dp_base(dp_base), .data_bank(data_bank), .prog_bank(prog_bank),
        .emu_mode(emu_mode), .idx_narrow(idx_narrow), .out_valid(out_valid),
        .ea_addr(ea_addr), .inc_mask(inc_mask), .dummy_addr(dummy_addr),
        .skip_cycle(skip_cycle), .step_addr_i(step_addr_i),
        .step_mask_i(step_mask_i), .step_down(step_down), .step_addr_o(step_addr_o)
    );

    function automatic string req_tag(input logic [3:0] m);
        case (m)
            4'd0: return "R2";
            4'd1, 4'd2, 4'd3, 4'd4: return "R3/R4";
            4'd5, 4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9, 4'd10: return "R8";
            4'd11: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic void model(output logic [23:0] e, output logic [23:0] mk,
                                  output logic [23:0] dm, output logic sk);
        logic [31:0] bank32, op16, op8, ix, t, lowb;
        logic        dz;
        bank32 = {8'h0, data_bank, 16'h0};
        op16   = {16'h0, operand[15:0]};
        op8    = {24'h0, operand[7:0]};
        ix     = (req_mode == 4'd3 || req_mode == 4'd4 || req_mode == 4'd10) ? {16'h0, idx_y} : {16'h0, idx_x};
        dz     = (dp_base[7:0] == 8'h00);
        e = '0; mk = '0; sk = 1'b0; dm = '0;
        case (req_mode)
            4'd0: begin t = bank32 + op16; e = t[23:0]; mk = 24'hFFFFFF; end
            4'd1, 4'd2, 4'd3, 4'd4: begin
                t = bank32 + op16 + ix; e = t[23:0];
                lowb = (op16 + ix) & 32'hFF;
                t = bank32 + (op16 & 32'hFF00) + lowb;
                mk = 24'hFFFFFF;
                sk = (req_mode == 4'd1 || req_mode == 4'd3) && idx_narrow && (e == t[23:0]);
            end
            4'd5: begin e = operand; mk = 24'hFFFFFF; end
            4'd6: begin t = {8'h0, operand} + {16'h0, idx_x}; e = t[23:0]; mk = 24'hFFFFFF; end
            4'd7: begin t = (op16 + {16'h0, idx_x}) & 32'hFFFF; e = {prog_bank, t[15:0]}; mk = 24'h00FFFF; end
            4'd8: begin
                t = ({16'h0, dp_base} + op8) & 32'hFFFF; e = t[23:0];
                mk = (dz && emu_mode) ? 24'h0000FF : 24'h00FFFF; sk = dz;
            end
            4'd9, 4'd10: begin
                t = ({16'h0, dp_base} + op8 + ix) & 32'hFFFF;
                if (dz && emu_mode) t = {16'h0, dp_base[15:8], t[7:0]};
                e = t[23:0]; mk = 24'h00FFFF; sk = dz;
            end
            4'd11: begin
                t = emu_mode ? {24'h000001, stk_ptr[7:0]} : {16'h0, stk_ptr};
                t = (t + op8) & 32'hFFFF; e = t[23:0]; mk = 24'h00FFFF;
            end
            default: ;
        endcase
        if (req_mode >= 4'd1 && req_mode <= 4'd4) dm = t[23:0];
        else dm = e;
    endfunction

    task automatic run_req(input string note);
        logic [23:0] e, mk, dm;
        logic sk;
        model(e, mk, dm, sk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (!out_valid || ea_addr !== e || inc_mask !== mk || dummy_addr !== dm || skip_cycle !== sk) begin
            errors++;
            $display("FAIL %s %s mode=%0d got v=%b ea=%h mask=%h dum=%h skip=%b exp v=1 ea=%h mask=%h dum=%h skip=%b",
                     req_tag(req_mode), note, req_mode, out_valid, ea_addr, inc_mask, dummy_addr, skip_cycle, e, mk, dm, sk);
        end
    endtask

    task automatic check_step(input logic [23:0] a, input logic [23:0] m, input logic d);
        logic [23:0] ex;
        step_addr_i = a; step_mask_i = m; step_down = d;
        #1;
        ex = (a & ~m) | ((d ? a - 24'd1 : a + 24'd1) & m);
        checks++;
        if (step_addr_o !== ex) begin
            errors++;
            $display("FAIL R10 step a=%h m=%h down=%b got %h exp %h", a, m, d, step_addr_o, ex);
        end
    endtask

    task automatic set_regs(input logic [3:0] m, input logic [23:0] op, input logic [15:0] x,
                            input logic [15:0] y, input logic [15:0] s, input logic [15:0] d,
                            input logic [7:0] db, input logic [7:0] pb, input logic em, input logic nr);
        req_mode = m; operand = op; idx_x = x; idx_y = y; stk_ptr = s; dp_base = d;
        data_bank = db; prog_bank = pb; emu_mode = em; idx_narrow = nr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [23:0] hold_ea, hold_mk;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        checks++;  // R1 reset state
        if (out_valid !== 1'b0 || ea_addr !== '0 || inc_mask !== '0 || dummy_addr !== '0 || skip_cycle !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset got v=%b ea=%h mask=%h exp all zero", out_valid, ea_addr, inc_mask);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 bank carry-free absolute
        set_regs(4'd0, 24'h00FFFF, 0, 0, 0, 0, 8'h12, 8'h00, 0, 0); run_req("abs");
        // R3 index carry into the bank byte
        set_regs(4'd1, 24'h00FFF0, 16'h0020, 0, 0, 0, 8'h12, 0, 0, 1); run_req("absx cross bank");
        // R4 narrow read, no page cross -> skip
        set_regs(4'd3, 24'h001210, 0, 16'h0005, 0, 0, 8'h7E, 0, 0, 1); run_req("absy no cross");
        // R4 wide index: no skip
        set_regs(4'd1, 24'h001210, 16'h0005, 0, 0, 0, 8'h7E, 0, 0, 0); run_req("absx wide");
        // R4 write never skips
        set_regs(4'd2, 24'h001210, 16'h0005, 0, 0, 0, 8'h7E, 0, 0, 1); run_req("absx write");
        // R5 long with 24-bit wrap
        set_regs(4'd6, 24'hFFFFF0, 16'h0020, 0, 0, 0, 0, 0, 0, 0); run_req("longx wrap");
        // R6 jump indirect wraps in program bank
        set_regs(4'd7, 24'h00FFF0, 16'h0020, 0, 0, 0, 8'h33, 8'h44, 0, 0); run_req("jindx wrap");
        // R7 aligned direct page in emulation -> byte mask
        set_regs(4'd8, 24'h0000FF, 0, 0, 0, 16'h2100, 8'h55, 0, 1, 1); run_req("dir aligned emu");
        // R7 unaligned direct page wraps 16 bits
        set_regs(4'd8, 24'h0000FF, 0, 0, 0, 16'hFFF1, 8'h55, 0, 0, 0); run_req("dir wrap");
        // R8 emulation page wrap
        set_regs(4'd9, 24'h0000F0, 16'h0020, 0, 0, 16'h0300, 0, 0, 1, 1); run_req("dirx emu page");
        // R8 native crosses page
        set_regs(4'd10, 24'h0000F0, 0, 16'h0020, 0, 16'h0300, 0, 0, 0, 1); run_req("diry native");
        // R9 emulation stack page
        set_regs(4'd11, 24'h000010, 0, 0, 16'hABF8, 0, 0, 0, 1, 1); run_req("stk emu");
        set_regs(4'd11, 24'h000010, 0, 0, 16'hFFF8, 0, 0, 0, 0, 0); run_req("stk native wrap");
        // R11 unused code
        set_regs(4'd13, 24'h123456, 16'h1111, 0, 0, 0, 8'h99, 8'h88, 0, 1); run_req("unused");

        // R1 outputs hold while idle and inputs move
        set_regs(4'd5, 24'hABCDEF, 0, 0, 0, 0, 0, 0, 0, 0); run_req("long");
        hold_ea = ea_addr; hold_mk = inc_mask;
        set_regs(4'd0, 24'h000001, 0, 0, 0, 0, 8'h01, 0, 0, 0);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || ea_addr !== hold_ea || inc_mask !== hold_mk) begin
            errors++;
            $display("FAIL R1 hold got v=%b ea=%h exp v=0 ea=%h", out_valid, ea_addr, hold_ea);
        end

        for (int i = 0; i < 800; i++) begin
            logic [15:0] d;
            d = $urandom();
            if ($urandom_range(0, 1) == 0) d[7:0] = 8'h00;
            set_regs($urandom_range(0, 15), $urandom(), $urandom_range(0, 3) == 0 ? 16'($urandom()) : 16'($urandom_range(0, 255)),
                     $urandom_range(0, 3) == 0 ? 16'($urandom()) : 16'($urandom_range(0, 255)),
                     $urandom(), d, $urandom(), $urandom(), $urandom_range(0, 1), $urandom_range(0, 1));
            run_req("random");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        // R10 stepper corners
        check_step(24'h12FFFF, 24'h00FFFF, 1'b0);
        check_step(24'h123400, 24'h0000FF, 1'b1);
        check_step(24'hFFFFFF, 24'hFFFFFF, 1'b0);
        check_step(24'h120000, 24'hFFFFFF, 1'b1);
        for (int i = 0; i < 200; i++) begin
            logic [23:0] mk;
            case ($urandom_range(0, 2))
                0: mk = 24'hFFFFFF;
                1: mk = 24'h00FFFF;
                default: mk = 24'h0000FF;
            endcase
            check_step($urandom(), mk, $urandom_range(0, 1));
        end
        @(negedge clk);
        finish_run();
    end
endmodule